// File: doc/BRIEF.md
# Banked Program Store with Built-in Sequencer

This block is a program store that carries its own program counter, so the unit that consumes instructions needs no separate sequencer. The store is split into banks; each bank holds a fixed number of words. The counter spans all banks together. Every operation slot, the word at the current address is sent out serially, one bit per clock (one clock is one bit time). In the first bit time of the next slot, a parity bit for that word is presented on its own pin.

A two-bit command, together with a condition bit and an external address, sets how the counter moves for the next slot. The counter can hold, step by one, return to zero, or jump to the external address. The jump is conditional: if the condition is false, the counter steps instead. The upper bits of the address pick the bank that drives the shared serial line. Every other bank drives zero. The contents are fixed by a closed-form fill function and a seed parameter, so no file is needed.

With the defaults there are 8 banks of 128 words of 20 bits, which gives a 10-bit address space of 1024 words.

Top module: `pss_top`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, `cur_addr` is 0, `word_first` is 1, `par_valid` is 0 and `bank_drive` is 8'b0000_0001. The first slot after reset carries the word at address 0.
- R2: Each slot lasts 20 clocks, and `word_first` is 1 only in its first clock. With the default `MSB_FIRST=0`, bit i of the word appears on `ser_data` in clock i of the slot, so bit 0 is sent first.
- R3: The word at address A is bits [19:0] of (A*40503) XOR (A<<11) XOR SEED, where SEED defaults to 0x5A5A5.
- R4: In the first clock of the slot that follows a word, `par_valid` is 1 and `ser_parity` is that word's odd-parity bit. The parity bit is the XNOR of its 20 bits, so the 21 bits together hold an odd number of ones. In every other clock, `par_valid` is 0.
- R5: `cmd`, `cond` and `jump_addr` are sampled only in the last clock of a slot, and the result sets `cur_addr` for the next slot. `cmd`=2'b00 keeps the same address, so the same word repeats.
- R6: `cmd`=2'b01 steps the address by one, and 1023 steps to 0.
- R7: `cmd`=2'b10 sets the next address to 0.
- R8: `cmd`=2'b11 loads `jump_addr` when `cond` is 1, and steps by one when `cond` is 0. `cond` has no effect on the other commands.
- R9: Address bits [9:7] pick the bank, and `bank_drive` is one-hot on that bank for the whole slot. Any bank that is not selected drives 0 on `ser_data`. This holds when a step or a jump crosses a bank edge.
- R10: `cur_addr` stays the same for the whole of a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 2 | Counter command: 00 hold, 01 step, 10 zero, 11 jump |
| cond | input | 1 | Condition for the jump command |
| jump_addr | input | 10 | External jump target |
| ser_data | output | 1 | Shared serial word output |
| ser_parity | output | 1 | Odd parity of the previous word |
| par_valid | output | 1 | Marks the parity bit time |
| word_first | output | 1 | First bit time of a slot |
| cur_addr | output | 10 | Address of the word being sent |
| bank_drive | output | 8 | One-hot bank currently driving |

## Verification
The counter is driven with runs of steps, repeated holds, and jumps with the condition false, which must fall back to a step. It is also driven with a step carrying a stray condition bit, which must be ignored. Jumps land in every bank, a step crosses from bank 0 into bank 1, and a jump to 1023 followed by a step shows the wrap. A clear, and a hold issued with a live jump address, separate the zero and hold paths from the load path. Every slot compares the serial bits against the fill formula, along with the parity, the one-hot bank and the address held at mid-slot.

// File: rtl/pss_pkg.sv
package pss_pkg;

   typedef enum logic [1:0] {
      PSS_HOLD = 2'b00,
      PSS_STEP = 2'b01,
      PSS_ZERO = 2'b10,
      PSS_JUMP = 2'b11
   } pss_cmd_e;

   // Closed-form fill for the fixed contents; the caller truncates to its word width.
   function automatic logic [31:0] pss_fill(input logic [31:0] addr, input logic [31:0] seed);
      return (addr * 32'd40503) ^ (addr << 11) ^ seed;
   endfunction

endpackage

// File: rtl/pss_bittimer.sv
module pss_bittimer #(
   parameter int WORD_W = 20,
   localparam int BIT_W = $clog2(WORD_W)
) (
   input  logic clk,
   input  logic rst_n,
   output logic first,
   output logic last
);

   logic [BIT_W-1:0] bit_idx;

   always_ff @(posedge clk) begin
      if (!rst_n)
         bit_idx <= '0;
      else if (last)
         bit_idx <= '0;
      else
         bit_idx <= bit_idx + BIT_W'(1);
   end

   assign first = (bit_idx == '0);
   assign last  = (bit_idx == BIT_W'(WORD_W - 1));

   // R2: a slot's last bit time is always followed by a first bit time
   p_slot_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> first);

   // R2: the first and last bit times are never the same clock
   p_first_not_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      first |-> !last);

endmodule

// File: rtl/pss_pc.sv
module pss_pc
   import pss_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  pss_cmd_e          cmd,
   input  logic              cond,
   input  logic [ADDR_W-1:0] jump_addr,
   output logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] pc_next
);

   logic [ADDR_W-1:0] pc_plus;

   assign pc_plus = pc + ADDR_W'(1);

   always_comb begin
      unique case (cmd)
         PSS_HOLD: pc_next = pc;
         PSS_STEP: pc_next = pc_plus;
         PSS_ZERO: pc_next = '0;
         PSS_JUMP: pc_next = cond ? jump_addr : pc_plus;
         default:  pc_next = pc;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pc <= '0;
      else if (advance)
         pc <= pc_next;
   end

   // R10: the address only moves at the slot boundary
   p_addr_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(pc));

   // R5: hold keeps the address
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && cmd == PSS_HOLD) |=> (pc == $past(pc)));

   // R6: step adds one, with wrap at the top
   p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && cmd == PSS_STEP) |=> (pc == $past(pc) + ADDR_W'(1)));

   // R7: zero command clears the counter
   p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && cmd == PSS_ZERO) |=> (pc == '0));

   // R8: taken jump loads the external address
   p_jump_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && cmd == PSS_JUMP && cond) |=> (pc == $past(jump_addr)));

   // R8: untaken jump behaves as a step
   p_jump_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && cmd == PSS_JUMP && !cond) |=> (pc == $past(pc) + ADDR_W'(1)));

endmodule

// File: rtl/pss_bank.sv
module pss_bank
   import pss_pkg::*;
#(
   parameter int          WORD_W    = 20,
   parameter int          LOCAL_W   = 7,
   parameter int          ADDR_W    = 10,
   parameter int          BANK_ID   = 0,
   parameter logic [31:0] SEED      = 32'h0005_A5A5,
   parameter bit          MSB_FIRST = 1'b0,
   localparam int         BANK_W    = ADDR_W - LOCAL_W,
   localparam int         WORDS     = 1 << LOCAL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] fetch_addr,
   output logic              drive,
   output logic              bit_out,
   output logic              par_out
);

   logic [WORD_W-1:0] tbl [WORDS];
   logic [WORD_W-1:0] shreg;
   logic [WORD_W-1:0] shreg_adv;
   logic [WORD_W-1:0] fetched;
   logic              sel_nxt;
   logic              sel_q;
   logic              word_par;
   logic              par_q;
   logic              head_bit;

   for (genvar i = 0; i < WORDS; i++) begin : g_fill
      assign tbl[i] = WORD_W'(pss_fill(32'(BANK_ID * WORDS + i), SEED));
   end

   assign sel_nxt = (fetch_addr[ADDR_W-1:LOCAL_W] == BANK_W'(BANK_ID));
   assign fetched = tbl[fetch_addr[LOCAL_W-1:0]];

   if (MSB_FIRST) begin : g_msb
      assign shreg_adv = {shreg[WORD_W-2:0], 1'b0};
      assign head_bit  = shreg[WORD_W-1];
   end else begin : g_lsb
      assign shreg_adv = {1'b0, shreg[WORD_W-1:1]};
      assign head_bit  = shreg[0];
   end

   always_ff @(posedge clk) begin
      if (load) begin
         sel_q    <= sel_nxt;
         shreg    <= sel_nxt ? fetched : '0;
         word_par <= sel_nxt & ~(^fetched);
         par_q    <= rst_n & word_par;
      end else begin
         shreg    <= shreg_adv;
         par_q    <= 1'b0;
      end
   end

   assign drive   = sel_q;
   assign bit_out = head_bit & sel_q;
   assign par_out = par_q;

   // R9: a bank that is not selected stays silent on the serial line
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !drive |-> !bit_out);

   // R4: the parity strobe from a bank lasts a single bit time
   p_par_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      par_out |=> !par_out);

endmodule

// File: rtl/pss_top.sv
module pss_top
   import pss_pkg::*;
#(
   parameter int          NUM_BANKS  = 8,
   parameter int          BANK_WORDS = 128,
   parameter int          WORD_W     = 20,
   parameter logic [31:0] SEED       = 32'h0005_A5A5,
   parameter bit          MSB_FIRST  = 1'b0,
   localparam int         LOCAL_W    = $clog2(BANK_WORDS),
   localparam int         BANK_W     = $clog2(NUM_BANKS),
   localparam int         ADDR_W     = LOCAL_W + BANK_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           cmd,
   input  logic                 cond,
   input  logic [ADDR_W-1:0]    jump_addr,
   output logic                 ser_data,
   output logic                 ser_parity,
   output logic                 par_valid,
   output logic                 word_first,
   output logic [ADDR_W-1:0]    cur_addr,
   output logic [NUM_BANKS-1:0] bank_drive
);

   if (NUM_BANKS < 2 || NUM_BANKS > 8 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("pss_top: NUM_BANKS must be 2, 4 or 8");
   end
   if (BANK_WORDS < 2 || (BANK_WORDS & (BANK_WORDS - 1)) != 0) begin : g_bad_words
      $error("pss_top: BANK_WORDS must be a power of two");
   end
   if (WORD_W < 2 || WORD_W > 32) begin : g_bad_width
      $error("pss_top: WORD_W must lie in 2..32");
   end

   logic                 first;
   logic                 last;
   logic [ADDR_W-1:0]    pc;
   logic [ADDR_W-1:0]    pc_next;
   logic [ADDR_W-1:0]    fetch_addr;
   logic                 load;
   logic                 pv_q;
   logic [NUM_BANKS-1:0] bank_bits;
   logic [NUM_BANKS-1:0] bank_pars;

   pss_bittimer #(.WORD_W(WORD_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .first (first),
      .last  (last)
   );

   pss_pc #(.ADDR_W(ADDR_W)) u_pc (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance   (last),
      .cmd       (pss_cmd_e'(cmd)),
      .cond      (cond),
      .jump_addr (jump_addr),
      .pc        (pc),
      .pc_next   (pc_next)
   );

   // Reset acts as a fetch of address 0 so the first slot is primed.
   assign fetch_addr = rst_n ? pc_next : '0;
   assign load       = !rst_n || last;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      pss_bank #(
         .WORD_W    (WORD_W),
         .LOCAL_W   (LOCAL_W),
         .ADDR_W    (ADDR_W),
         .BANK_ID   (b),
         .SEED      (SEED),
         .MSB_FIRST (MSB_FIRST)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .load       (load),
         .fetch_addr (fetch_addr),
         .drive      (bank_drive[b]),
         .bit_out    (bank_bits[b]),
         .par_out    (bank_pars[b])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pv_q <= 1'b0;
      else
         pv_q <= last;
   end

   assign ser_data   = |bank_bits;
   assign ser_parity = |bank_pars;
   assign par_valid  = pv_q;
   assign word_first = first;
   assign cur_addr   = pc;

   // R9: exactly one bank drives at any time
   p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(bank_drive));

   // R9: the driving bank agrees with the counter's upper bits
   p_bank_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bank_drive[pc[ADDR_W-1:LOCAL_W]]);

   // R4: parity strobe only in the first bit time of a slot
   p_par_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      par_valid |-> word_first);

   // R4: parity pin is quiet outside its bit time
   p_par_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ser_parity |-> par_valid);

   // R1: leaving reset starts at address 0 on a slot edge
   p_reset_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cur_addr == '0 && word_first && !par_valid));

endmodule

// File: tb/pss_top_bench.sv
`timescale 1ns/1ps
module pss_top_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cmd = 2'b00;
   logic       cond = 1'b0;
   logic [9:0] jump_addr = '0;
   logic       ser_data, ser_parity, par_valid, word_first;
   logic [9:0] cur_addr;
   logic [7:0] bank_drive;

   int  n_checks = 0;
   int  n_fail   = 0;
   int  model_pc = 0;
   int  exp_q[$];
   bit  mon_on   = 1'b0;

   always #4 clk = ~clk;

   pss_top u_pss_top (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd        (cmd),
      .cond       (cond),
      .jump_addr  (jump_addr),
      .ser_data   (ser_data),
      .ser_parity (ser_parity),
      .par_valid  (par_valid),
      .word_first (word_first),
      .cur_addr   (cur_addr),
      .bank_drive (bank_drive)
   );

   function automatic logic [19:0] exp_word(input int a);
      logic [31:0] v;
      v = (32'(a) * 32'd40503) ^ (32'(a) << 11) ^ 32'h0005_A5A5;
      return v[19:0];
   endfunction

   function automatic int next_pc(input logic [1:0] c, input logic k, input int j, input int p);
      case (c)
         2'b00:   return p;
         2'b01:   return (p + 1) % 1024;
         2'b10:   return 0;
         default: return k ? j : (p + 1) % 1024;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // Driver: waits for a slot start, sets the command, queues the expected next address.
   task automatic issue(input logic [1:0] c, input logic k, input int j);
      @(negedge clk);
      while (!word_first) @(negedge clk);
      cmd       = c;
      cond      = k;
      jump_addr = 10'(j);
      model_pc  = next_pc(c, k, j, model_pc);
      exp_q.push_back(model_pc);
   endtask

   // Monitor: per slot, compares address, bank, serial bits and following parity.
   initial begin
      int          nb = 0;
      int          prev_addr = 0;
      bit          have_prev = 1'b0;
      logic [19:0] got = '0;
      forever begin
         @(negedge clk);
         if (rst_n && mon_on) begin
            if (word_first) begin
               if (have_prev) begin
                  chk(got == exp_word(prev_addr), "R2 R3", "serial word", got, exp_word(prev_addr));
                  chk(par_valid == 1'b1, "R4", "parity strobe", par_valid, 1);
                  chk(ser_parity == ~(^exp_word(prev_addr)), "R4", "odd parity",
                      ser_parity, ~(^exp_word(prev_addr)));
               end
               nb = 0;
               if (exp_q.size() > 0) begin
                  prev_addr = exp_q.pop_front();
                  have_prev = 1'b1;
                  chk(cur_addr == 10'(prev_addr), "R5 R6 R7 R8", "slot address", cur_addr, prev_addr);
                  chk(bank_drive == 8'(1 << (prev_addr >> 7)), "R9", "bank select",
                      bank_drive, 1 << (prev_addr >> 7));
               end else begin
                  have_prev = 1'b0;
               end
            end
            if (have_prev) begin
               if (nb < 20) got[nb] = ser_data;
               if (nb == 10) begin
                  chk(par_valid == 1'b0, "R4", "parity strobe mid-slot", par_valid, 0);
                  chk(word_first == 1'b0, "R2", "first flag mid-slot", word_first, 0);
                  chk(cur_addr == 10'(prev_addr), "R10", "address held mid-slot", cur_addr, prev_addr);
               end
               nb++;
            end
         end
      end
   end

   initial begin
      bit timed_out = 1'b0;
      exp_q.push_back(0);
      fork
         begin
            repeat (3) @(posedge clk);
            @(negedge clk);
            // R1: reset state
            chk(cur_addr == 10'd0, "R1", "reset address", cur_addr, 0);
            chk(word_first == 1'b1, "R1", "reset first flag", word_first, 1);
            chk(par_valid == 1'b0, "R1", "reset parity strobe", par_valid, 0);
            chk(bank_drive == 8'b0000_0001, "R1", "reset bank", bank_drive, 1);
            @(posedge clk);
            rst_n  <= 1'b1;
            mon_on = 1'b1;
            issue(2'b01, 1'b0, 0);    // R6 step -> 1
            issue(2'b01, 1'b0, 0);    // -> 2
            issue(2'b01, 1'b0, 0);    // -> 3
            issue(2'b00, 1'b0, 0);    // R5 hold -> 3
            issue(2'b00, 1'b1, 77);   // R5 hold ignores cond/jump -> 3
            issue(2'b01, 1'b1, 600);  // R8 cond ignored on step -> 4
            issue(2'b11, 1'b0, 500);  // R8 untaken jump -> 5
            issue(2'b11, 1'b1, 127);  // R8 taken jump -> 127
            issue(2'b01, 1'b0, 0);    // R9 bank edge -> 128
            issue(2'b11, 1'b1, 300);  // R9 bank 2
            issue(2'b11, 1'b1, 450);  // bank 3
            issue(2'b11, 1'b1, 600);  // bank 4
            issue(2'b11, 1'b1, 700);  // bank 5
            issue(2'b11, 1'b1, 800);  // bank 6
            issue(2'b11, 1'b1, 1000); // bank 7
            issue(2'b11, 1'b1, 1023); // top address
            issue(2'b01, 1'b0, 0);    // R6 wrap -> 0
            issue(2'b01, 1'b0, 0);    // -> 1
            issue(2'b11, 1'b1, 900);  // -> 900
            issue(2'b10, 1'b1, 55);   // R7 zero -> 0
            issue(2'b00, 1'b1, 55);   // hold at 0
            issue(2'b01, 1'b0, 0);    // -> 1
            repeat (45) @(posedge clk);
            mon_on = 1'b0;
         end
         begin
            repeat (100000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) chk(1'b0, "R2", "watchdog expired", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule